// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block brings a voltage regulator controller out of shutdown in a fixed order. It watches three qualified digital enables: bias power-on-reset good, power enable and termination-rail enable. While any of them is low the block stays in shutdown. In shutdown the PWM output-enable is low, so the phase outputs are tri-stated, and the reference code is zero.

Once all three enables are high, the block waits a fixed number of clocks. It then ramps the reference code up to a boot code, one code step per programmable number of clocks. It holds at the boot code for a fixed interval, and also until the VID input has been stable long enough to trust. It then reads the VID. A valid VID starts a second ramp, up or down, to the VID code minus a fixed offset, and the ready flag rises when that ramp lands. The off code instead forces a latched shutdown. Only dropping and re-raising an enable clears it.

The ramp generator is modelled as a code counter, and all delays are counted in clock cycles. Every input and output is a plain level signal. No data stream crosses the boundary, so there is no handshake.

Top module: `vreg_startup_seq`

## Requirements
- R1: After reset, and whenever the block is in shutdown, `pwm_oe` is 0, `ref_code` is 0 and `ready` is 0.
- R2: The block leaves shutdown only while `por_ok`, `pwr_en` and `rail_en` are all 1. `pwm_oe` rises on the first clock edge at which all three are seen high.
- R3: After that edge, `ref_code` stays 0 for START_DLY cycles. It then rises by exactly one code every STEP_DIV cycles, so the first step lands START_DLY+STEP_DIV edges after the enabling edge.
- R4: The first ramp stops at BOOT_CODE, and `ref_code` stays at BOOT_CODE during the hold.
- R5: The VID is taken only after at least HOLD_DLY cycles of hold, and only once `vid_code` has been unchanged for QUAL_CYC consecutive cycles. A VID that keeps changing extends the hold indefinitely.
- R6: A VID other than OFF_CODE starts a second ramp to VID−OFFSET_CODE, floored at 0, stepping up or down from BOOT_CODE. `ready` rises when `ref_code` reaches that target, and the target then stays fixed while `ready` is 1.
- R7: If the VID taken is OFF_CODE, the block enters a latched shutdown with R1 outputs. It stays there whatever `vid_code` does, until an enable is deasserted and then reasserted.
- R8: Deasserting any enable in any state gives `pwm_oe`=0, `ref_code`=0 and `ready`=0 after the next clock edge.
- R9: While `pwm_oe` stays 1, `ref_code` changes by at most one code per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above power-on-reset threshold |
| pwr_en | input | 1 | Power sequencing enable |
| rail_en | input | 1 | Termination rail enable |
| vid_code | input | CODE_W | Requested voltage code |
| pwm_oe | output | 1 | PWM output enable; 0 tri-states the phases |
| ref_code | output | CODE_W | Reference (DAC) code for the regulation loop |
| ready | output | 1 | Soft-start finished, output in regulation |

## Verification
The hardest case to reach from the ports is the hold at the boot code when the VID never settles. The hold timer has already expired, so the only thing keeping the block at boot is the stability qualifier. The bench reaches this by toggling `vid_code` every two cycles throughout the hold. It checks that the reference stays pinned at boot with `ready` low, then stops toggling and expects the second ramp to start. The latched off-code shutdown is reached by presenting the off code at the end of the hold. The bench then changes `vid_code` to a valid value and checks that nothing restarts until an enable is cycled.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_DELAY,
    ST_RAMP_BOOT,
    ST_HOLD,
    ST_RAMP_VID,
    ST_RUN,
    ST_LATCH
  } vss_state_e;
endpackage

// File: rtl/vss_cycle_timer.sv
// Saturating up-counter of cycles spent in the current state.
module vss_cycle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != MAXV) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vss_vid_qual.sv
// Flags a VID code that has been unchanged for QUAL_CYC cycles.
module vss_vid_qual #(
  parameter int CODE_W   = 8,
  parameter int QUAL_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vid,
  output logic              stable
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [CODE_W-1:0] last_vid;
  logic [QW-1:0]     same_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vid <= '0;
      same_cnt <= '0;
    end else begin
      last_vid <= vid;
      if (vid != last_vid)    same_cnt <= '0;
      else if (same_cnt != QMAX) same_cnt <= same_cnt + 1'b1;
    end
  end

  assign stable = (same_cnt == QMAX) && (vid == last_vid);
endmodule

// File: rtl/vss_ref_ramp.sv
// Reference code stepper: one code toward target every STEP_DIV cycles.
module vss_ref_ramp #(
  parameter int CODE_W   = 8,
  parameter int STEP_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] ref_code,
  output logic              at_target
);
  localparam int DW = $clog2(STEP_DIV + 1);
  localparam logic [DW-1:0] DLAST = DW'(STEP_DIV - 1);

  logic [DW-1:0] div_cnt;

  assign at_target = (ref_code == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_code <= '0;
      div_cnt  <= '0;
    end else if (clr) begin
      ref_code <= '0;
      div_cnt  <= '0;
    end else if (run && !at_target) begin
      if (div_cnt == DLAST) begin
        div_cnt <= '0;
        if (target > ref_code) ref_code <= ref_code + 1'b1;
        else                   ref_code <= ref_code - 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end else begin
      div_cnt <= '0;
    end
  end
endmodule

// File: rtl/vreg_startup_seq.sv
module vreg_startup_seq
  import vss_pkg::*;
#(
  parameter int              CODE_W      = 8,
  parameter int              START_DLY   = 68000,
  parameter int              HOLD_DLY    = 4250,
  parameter int              QUAL_CYC    = 25,
  parameter int              STEP_DIV    = 64,
  parameter logic [CODE_W-1:0] BOOT_CODE   = 8'd100,
  parameter logic [CODE_W-1:0] OFF_CODE    = 8'hFF,
  parameter logic [CODE_W-1:0] OFFSET_CODE = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              pwr_en,
  input  logic              rail_en,
  input  logic [CODE_W-1:0] vid_code,
  output logic              pwm_oe,
  output logic [CODE_W-1:0] ref_code,
  output logic              ready
);
  localparam int TMAX = (START_DLY > HOLD_DLY) ? START_DLY : HOLD_DLY;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] START_LAST = TW'(START_DLY - 1);
  localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_DLY - 1);

  vss_state_e        st, nxt;
  logic              all_en;
  logic [TW-1:0]     st_cnt;
  logic              vid_ok;
  logic              at_tgt;
  logic [CODE_W-1:0] vid_tgt, ramp_tgt, vid_less_ofs;

  assign all_en       = por_ok && pwr_en && rail_en;
  assign vid_less_ofs = (vid_code > OFFSET_CODE) ? (vid_code - OFFSET_CODE) : '0;

  always_comb begin
    nxt = st;
    if (!all_en) begin
      nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:       nxt = ST_DELAY;
        ST_DELAY:     if (st_cnt == START_LAST) nxt = ST_RAMP_BOOT;
        ST_RAMP_BOOT: if (at_tgt) nxt = ST_HOLD;
        ST_HOLD:      if (st_cnt >= HOLD_LAST && vid_ok)
                        nxt = (vid_code == OFF_CODE) ? ST_LATCH : ST_RAMP_VID;
        ST_RAMP_VID:  if (at_tgt) nxt = ST_RUN;
        ST_RUN:       nxt = ST_RUN;
        ST_LATCH:     nxt = ST_LATCH;
        default:      nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      vid_tgt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_HOLD && nxt == ST_RAMP_VID) vid_tgt <= vid_less_ofs;
    end
  end

  assign ramp_tgt = (st == ST_RAMP_VID || st == ST_RUN) ? vid_tgt : BOOT_CODE;

  vss_cycle_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nxt != st),
    .cnt   (st_cnt)
  );

  vss_vid_qual #(.CODE_W(CODE_W), .QUAL_CYC(QUAL_CYC)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .vid    (vid_code),
    .stable (vid_ok)
  );

  vss_ref_ramp #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (nxt == ST_OFF || nxt == ST_LATCH),
    .run       (st == ST_RAMP_BOOT || st == ST_RAMP_VID),
    .target    (ramp_tgt),
    .ref_code  (ref_code),
    .at_target (at_tgt)
  );

  assign pwm_oe = (st != ST_OFF) && (st != ST_LATCH);
  assign ready  = (st == ST_RUN);
endmodule

// File: rtl/vss_checker.sv
module vss_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_ok,
  input logic              pwr_en,
  input logic              rail_en,
  input logic              pwm_oe,
  input logic [CODE_W-1:0] ref_code,
  input logic              ready
);
  a_r8_drop_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(por_ok && pwr_en && rail_en) |=> (!pwm_oe && ref_code == '0 && !ready));

  a_r2_rise_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_oe) |-> $past(por_ok && pwr_en && rail_en));

  a_r9_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_oe |=> (!pwm_oe || ref_code == $past(ref_code)
                || ref_code == $past(ref_code) + 1'b1
                || ref_code + 1'b1 == $past(ref_code)));

  a_r6_ready_on: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pwm_oe);

  a_r6_ready_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (!ready || $stable(ref_code)));

  a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> (!ready && ref_code == '0));
endmodule

bind vreg_startup_seq vss_checker #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_ok   (por_ok),
  .pwr_en   (pwr_en),
  .rail_en  (rail_en),
  .pwm_oe   (pwm_oe),
  .ref_code (ref_code),
  .ready    (ready)
);

// File: tb/vreg_startup_seq_bench.sv
module vreg_startup_seq_bench;
  localparam int SD = 20, HD = 10, QC = 4, DIV = 2;
  localparam logic [7:0] BOOT = 8'd40, OFFC = 8'hFF, OFS = 8'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_ok = 0, pwr_en = 0, rail_en = 0;
  logic [7:0] vid_code = 8'd60;
  logic pwm_oe, ready;
  logic [7:0] ref_code;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vreg_startup_seq #(.CODE_W(8), .START_DLY(SD), .HOLD_DLY(HD), .QUAL_CYC(QC),
    .STEP_DIV(DIV), .BOOT_CODE(BOOT), .OFF_CODE(OFFC), .OFFSET_CODE(OFS)) u_vreg_startup_seq (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .pwr_en(pwr_en), .rail_en(rail_en),
    .vid_code(vid_code), .pwm_oe(pwm_oe), .ref_code(ref_code), .ready(ready));

  // {vid, expected final ref, expect latched-off}
  localparam logic [16:0] VEC [5] = '{
    {8'd60, 8'd58, 1'b0},   // R6 ramp up
    {8'd20, 8'd18, 1'b0},   // R6 ramp down
    {8'd1,  8'd0,  1'b0},   // R6 floor at 0
    {8'd42, 8'd40, 1'b0},   // R6 target equals boot
    {8'hFF, 8'd0,  1'b1}    // R7 off code
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic a, input logic b, input logic c);
    por_ok = a; pwr_en = b; rail_en = c;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 pwm_oe at reset", pwm_oe, 0);
    chk("R1 ref at reset", ref_code, 0);
    chk("R1 ready at reset", ready, 0);
    rst_n = 1'b1;
    cyc(2);

    // Vector table: full start-up per VID
    for (int i = 0; i < 5; i++) begin
      set_en(0, 0, 0);
      vid_code = VEC[i][16:9];
      cyc(3);
      set_en(1, 1, 1);
      cyc(400);
      chk($sformatf("R6/R7 vec%0d ref", i), ref_code, VEC[i][8:1]);
      chk($sformatf("R6/R7 vec%0d ready", i), ready, !VEC[i][0]);
      chk($sformatf("R6/R7 vec%0d pwm_oe", i), pwm_oe, !VEC[i][0]);
    end

    // R2: any two enables are not enough
    for (int m = 0; m < 3; m++) begin
      set_en(0, 0, 0);
      cyc(2);
      set_en(m != 0, m != 1, m != 2);
      cyc(60);
      chk($sformatf("R2 missing enable %0d pwm_oe", m), pwm_oe, 0);
      chk($sformatf("R2 missing enable %0d ref", m), ref_code, 0);
    end

    // R3: exact delay and first step
    set_en(0, 0, 0);
    vid_code = 8'd60;
    cyc(3);
    set_en(1, 1, 1);
    cyc(1);
    chk("R2 pwm_oe after enabling edge", pwm_oe, 1);
    cyc(SD + DIV - 1);
    chk("R3 ref before first step", ref_code, 0);
    cyc(1);
    chk("R3 first step", ref_code, 1);
    cyc(DIV - 1);
    chk("R3 no early second step", ref_code, 1);
    cyc(1);
    chk("R3 second step", ref_code, 2);

    // R4/R5: hold lasts at least HOLD_DLY
    while (ref_code != BOOT) cyc(1);
    cyc(HD);
    chk("R4 ref held at boot", ref_code, BOOT);
    chk("R5 not ready during hold", ready, 0);
    cyc(300);
    chk("R6 ready after ramp", ready, 1);
    // R8: drop rail enable while running
    rail_en = 0;
    cyc(1);
    chk("R8 pwm_oe after drop", pwm_oe, 0);
    chk("R8 ref after drop", ref_code, 0);
    chk("R8 ready after drop", ready, 0);

    // R5: unstable VID keeps the hold
    set_en(1, 1, 1);
    while (ref_code != BOOT) cyc(1);
    for (int k = 0; k < 60; k++) begin
      vid_code = (k % 4 < 2) ? 8'd70 : 8'd71;
      cyc(1);
    end
    chk("R5 toggling vid holds boot", ref_code, BOOT);
    chk("R5 toggling vid not ready", ready, 0);
    vid_code = 8'd70;
    cyc(200);
    chk("R5 stable vid resumes ramp", ref_code, 68);
    chk("R6 ready after resume", ready, 1);

    // R8: drop during the first ramp
    set_en(0, 0, 0);
    cyc(2);
    set_en(1, 1, 1);
    cyc(SD + 10);
    pwr_en = 0;
    cyc(1);
    chk("R8 drop in ramp ref", ref_code, 0);
    chk("R8 drop in ramp pwm_oe", pwm_oe, 0);

    // R7: latched off code ignores later valid VID
    set_en(0, 0, 0);
    vid_code = OFFC;
    cyc(2);
    set_en(1, 1, 1);
    cyc(300);
    chk("R7 latched pwm_oe", pwm_oe, 0);
    vid_code = 8'd50;
    cyc(300);
    chk("R7 latch holds pwm_oe", pwm_oe, 0);
    chk("R7 latch holds ref", ref_code, 0);
    por_ok = 0;
    cyc(2);
    por_ok = 1;
    cyc(400);
    chk("R7 re-enable restarts ready", ready, 1);
    chk("R7 re-enable ref", ref_code, 48);

    finish_run();
  end
endmodule